// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames in which every character carries one extra flag bit. The flag bit follows the data bits and marks a character as an address (flag 1) or as data (flag 0). A shared line can carry traffic for many stations. Each station arms a wake-up gate and then sleeps through data characters meant for other stations. When an address character arrives, the station wakes. Software then checks the address and either keeps listening or re-arms the gate.

The serial line idles high. A frame has one low start bit, eight data bits with the least significant bit first, the flag bit and one high stop bit. A baud strobe input paces the receiver, with sixteen strobes per bit time, and each bit is sampled near its middle. A small register port gives access to three registers:

- a control register with the address-mode enable, the wake-up gate and the interrupt enable;
- a sticky status register;
- the received byte.

Two level interrupt outputs report received data and receive errors.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0, the data register (address 2) reads 0, and both interrupt outputs are low.
- R2: A frame of one low start bit, 8 data bits least significant bit first, a flag bit and a high stop bit is sampled at mid-bit, with 16 baud strobes per bit. On completion the byte is placed in the data register and the full flag (status bit 0) is set.
- R3: When address mode (control bit 0) is 1 and the wake-up gate (control bit 1) is 1, a frame whose flag bit is 0 is discarded. The data register does not change, no status flag is set and no interrupt is raised.
- R4: When address mode and the wake-up gate are both 1 and a frame with flag bit 1 arrives, the address flag (status bit 3) is set. The hardware clears the wake-up gate to 0, and the byte is delivered as in R2.
- R5: With the interrupt enable (control bit 2) set, the receive interrupt follows the full flag, and the error interrupt follows the logical OR of the framing-error and overrun flags. This normal flagging resumes after a wake-up frame.
- R6: When address mode is 0, the wake-up gate has no effect, and frames with flag bit 0 are received normally.
- R7: A stop bit sampled low sets the framing-error flag (status bit 1). The byte is still delivered.
- R8: A frame that completes while the full flag is 1 sets the overrun flag (status bit 2), and the data register keeps its old byte.
- R9: Writing to the status register clears each flag whose written bit is 0. A written 1 leaves that flag unchanged.
- R10: Software can clear the wake-up gate by writing 0 to control bit 1. Frames with flag bit 0 are then accepted.
- R11: A low pulse on the line that is high again at mid start bit is ignored and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Baud strobe, 16 per bit time |
| rxd | input | 1 | Serial input, idles high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The hardest case to reach is the wake-up sequence. Address mode and the gate are armed, a data frame must leave the block untouched, and then an address frame must both clear the gate and deliver its byte. A following bad-stop frame must then raise overrun and framing error together.

The stimulus drives complete serial frames through the line in that order. Between frames it reads the control and status registers back. A glitch pulse and a scoreboard run of bytes with single set bits at each end round out the sampling checks.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    localparam int DATA_W = 8;
    localparam int STAT_W = 4;
    localparam int CTRL_W = 3;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_FLAG,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              stop_ok;
    } rx_frame_t;

    typedef struct packed {
        logic irq_en;   // bit 2
        logic wake_en;  // bit 1
        logic mp_mode;  // bit 0
    } ctrl_t;

    typedef struct packed {
        logic mp_flag;   // bit 3
        logic overrun;   // bit 2
        logic frame_err; // bit 1
        logic full;      // bit 0
    } stat_t;

    function automatic logic frame_is_gated(ctrl_t c, logic mpb);
        return c.mp_mode & c.wake_en & ~mpb;
    endfunction
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpr_bit_engine.sv
module mpr_bit_engine
    import mpr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    output logic      frm_valid,
    output rx_frame_t frm
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              mpb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            mpb_q     <= 1'b0;
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!rxd) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF_M1) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= rxd ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {rxd, shreg[DATA_W-1:1]};
                            if (idx == IDX_END) state <= ST_FLAG;
                            else                idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_FLAG: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            mpb_q <= rxd;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            frm.data    <= shreg;
                            frm.mpb     <= mpb_q;
                            frm.stop_ok <= rxd;
                            frm_valid   <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpr_regfile.sv
module mpr_regfile
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  rx_frame_t         frm,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_rx,
    output logic              irq_err,
    output ctrl_t             ctrl_q,
    output stat_t             stat_q,
    output logic [DATA_W-1:0] data_q
);
    ctrl_t             ctrl_n;
    stat_t             stat_n;
    logic [DATA_W-1:0] data_n;
    logic              gated, accept, wake;
    logic              unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:STAT_W];

    assign gated  = frm_valid & frame_is_gated(ctrl_q, frm.mpb);
    assign accept = frm_valid & ~gated;
    assign wake   = accept & ctrl_q.mp_mode & ctrl_q.wake_en & frm.mpb;

    always_comb begin
        ctrl_n = ctrl_q;
        if (wr_en && addr == ADDR_CTRL) ctrl_n = ctrl_t'(wdata[CTRL_W-1:0]);
        if (wake) ctrl_n.wake_en = 1'b0;
    end

    always_comb begin
        stat_n = stat_q;
        data_n = data_q;
        if (wr_en && addr == ADDR_STAT)
            stat_n = stat_t'(stat_q & wdata[STAT_W-1:0]);
        if (accept) begin
            if (stat_q.full) begin
                stat_n.overrun = 1'b1;
            end else begin
                stat_n.full = 1'b1;
                data_n      = frm.data;
            end
            if (!frm.stop_ok) stat_n.frame_err = 1'b1;
            if (frm.mpb)      stat_n.mp_flag   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
            data_q <= data_n;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rdata = DATA_W'(ctrl_q);
            ADDR_STAT: rdata = DATA_W'(stat_q);
            ADDR_DATA: rdata = data_q;
            default:   rdata = '0;
        endcase
    end

    assign irq_rx  = ctrl_q.irq_en & stat_q.full;
    assign irq_err = ctrl_q.irq_en & (stat_q.frame_err | stat_q.overrun);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mpr_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_rx,
    output logic              irq_err
);
    logic              rxd_s;
    logic              frm_valid;
    rx_frame_t         frm;
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [DATA_W-1:0] data_q;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
    );

    mpr_bit_engine #(.OVS(OVS)) u_engine (
        .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd_s),
        .frm_valid(frm_valid), .frm(frm)
    );

    mpr_regfile u_regs (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm(frm),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_rx(irq_rx), .irq_err(irq_err),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .data_q(data_q)
    );
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker
    import mpr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_valid,
    input rx_frame_t         frm,
    input ctrl_t             ctrl_q,
    input stat_t             stat_q,
    input logic [DATA_W-1:0] data_q,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata
);
    logic is_gated;
    assign is_gated = ctrl_q.mp_mode & ctrl_q.wake_en & ~frm.mpb;

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        frm_valid && is_gated && !wr_en |=> $stable(stat_q) && $stable(data_q)); // R3
    AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        frm_valid && ctrl_q.mp_mode && ctrl_q.wake_en && frm.mpb
        |=> !ctrl_q.wake_en && stat_q.mp_flag); // R4
    AST_NO_GATE_PLAIN: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !ctrl_q.mp_mode && !wr_en |=> stat_q.full); // R6
    AST_FRAME_ERR: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !is_gated && !frm.stop_ok |=> stat_q.frame_err); // R7
    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !is_gated && stat_q.full |=> stat_q.overrun && $stable(data_q)); // R8
    AST_W1_NOEFFECT: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == ADDR_STAT && wdata[STAT_W-1:0] == '1 && !frm_valid
        |=> $stable(stat_q)); // R9
endmodule

bind mp_uart_rx mpr_checker u_chk (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm(frm),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .data_q(data_q),
    .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/tb_mp_uart_rx.sv
`timescale 1ns/1ps
module tb_mp_uart_rx;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_rx, irq_err;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    logic mon_on = 1'b0;
    logic mon_busy = 1'b0;

    always #5 clk = ~clk;

    mp_uart_rx dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic mpb, input logic stop);
        logic [10:0] bits;
        bits = {stop, mpb, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            rxd = bits[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic push_frame(input logic [7:0] d);
        exp_q.push_back(d);
        send_frame(d, 1'b0, 1'b1);
    endtask

    initial begin : monitor
        logic [7:0] got, want;
        forever begin
            @(negedge clk);
            if (mon_on && irq_rx) begin
                mon_busy = 1'b1;
                bus_read(2'd2, got);
                if (exp_q.size() == 0) begin
                    check("R2 scoreboard unexpected byte", got, 8'hxx);
                end else begin
                    want = exp_q.pop_front();
                    check("R2 scoreboard byte", got, want);
                end
                bus_write(2'd1, 8'hFE);
                @(negedge clk);
                mon_busy = 1'b0;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, v); check("R1 ctrl", v, 8'h00);
        bus_read(2'd1, v); check("R1 stat", v, 8'h00);
        bus_read(2'd2, v); check("R1 data", v, 8'h00);
        check("R1 irqs", {6'd0, irq_rx, irq_err}, 8'h00);

        // R2 plain reception
        send_frame(8'hA5, 1'b0, 1'b1);
        bus_read(2'd2, v); check("R2 data", v, 8'hA5);
        bus_read(2'd1, v); check("R2 stat full", v, 8'h01);
        bus_write(2'd1, 8'hFE);

        // R7 bad stop bit
        send_frame(8'hC3, 1'b0, 1'b0);
        bus_read(2'd1, v); check("R7 stat ferr", v, 8'h03);
        bus_read(2'd2, v); check("R7 data", v, 8'hC3);

        // R9 write-one no effect, write-zero clears
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, v); check("R9 write ones", v, 8'h03);
        bus_write(2'd1, 8'hFD);
        bus_read(2'd1, v); check("R9 clear ferr only", v, 8'h01);
        bus_write(2'd1, 8'h00);

        // R6 gate ignored without address mode
        bus_write(2'd0, 8'h02);
        send_frame(8'h99, 1'b0, 1'b1);
        bus_read(2'd1, v); check("R6 stat", v, 8'h01);
        bus_read(2'd2, v); check("R6 data", v, 8'h99);
        bus_write(2'd1, 8'h00);

        // R3 gated data frame discarded
        bus_write(2'd0, 8'h07);
        send_frame(8'h11, 1'b0, 1'b1);
        bus_read(2'd1, v); check("R3 stat", v, 8'h00);
        bus_read(2'd2, v); check("R3 data", v, 8'h99);
        check("R3 irqs", {6'd0, irq_rx, irq_err}, 8'h00);
        send_frame(8'h22, 1'b0, 1'b0);
        bus_read(2'd1, v); check("R3 stat bad stop", v, 8'h00);

        // R4 wake-up frame
        send_frame(8'h3C, 1'b1, 1'b1);
        bus_read(2'd0, v); check("R4 ctrl gate cleared", v, 8'h05);
        bus_read(2'd1, v); check("R4 stat", v, 8'h09);
        bus_read(2'd2, v); check("R4 data", v, 8'h3C);
        check("R5 irq_rx", {7'd0, irq_rx}, 8'h01);
        check("R5 irq_err low", {7'd0, irq_err}, 8'h00);

        // R8 / R5 overrun with framing error after wake-up
        send_frame(8'h77, 1'b0, 1'b0);
        bus_read(2'd1, v); check("R8 stat", v, 8'h0F);
        bus_read(2'd2, v); check("R8 data kept", v, 8'h3C);
        check("R5 irq_err", {7'd0, irq_err}, 8'h01);
        bus_write(2'd0, 8'h01);
        check("R5 irqs masked", {6'd0, irq_rx, irq_err}, 8'h00);
        bus_write(2'd1, 8'h00);

        // R10 software clears the gate
        bus_write(2'd0, 8'h07);
        bus_write(2'd0, 8'h05);
        bus_read(2'd0, v); check("R10 ctrl", v, 8'h05);
        send_frame(8'h42, 1'b0, 1'b1);
        bus_read(2'd1, v); check("R10 stat", v, 8'h01);
        bus_read(2'd2, v); check("R10 data", v, 8'h42);
        bus_write(2'd1, 8'h00);

        // R11 start glitch rejected
        @(negedge clk);
        rxd = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        bus_read(2'd1, v); check("R11 stat", v, 8'h00);
        bus_read(2'd2, v); check("R11 data", v, 8'h42);

        // R2 scoreboard run, bit order
        bus_write(2'd0, 8'h04);
        mon_on = 1'b1;
        push_frame(8'h01);
        push_frame(8'h80);
        push_frame(8'h5A);
        push_frame(8'hFF);
        push_frame(8'h00);
        repeat (50) @(negedge clk);
        while (mon_busy) @(negedge clk);
        mon_on = 1'b0;
        check("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule